// File: doc/BRIEF.md
# Four-Channel Pulse-Width DAC

This block turns four 8-bit duty values into four pulse-width waveforms that share one repetition period. A free-running timebase divides the system clock by a prescale factor into ticks and counts 256 ticks per period. Each channel compares the tick count with its active duty value and drives an open-drain pin, so a logic 1 on a pin output switches the pull-down transistor on and holds the pin low. With a 2.25 MHz tick rate the period repeats at about 8.79 kHz, roughly 114 us.

Duty values arrive as load commands on a valid/ready stream. Each command names a channel and carries a byte. The byte goes into that channel's shadow register. All four shadow registers are copied into the active registers together on the last clock of a period, so a new value takes effect only from the next period on and the old duty may keep running for up to one full period. The block never applies back-pressure: `ld_ready` is always high, and a command is accepted on every rising clock edge where `ld_valid` is high.

A small configuration write sets a per-pin select mask and a port register. A pin whose select bit is 0 follows its port bit. A pin whose select bit is 1 shows the pulse-width waveform from the next clock on, using the current count and the current active duty.

Top module: `quad_pwm_dac`

## Requirements
- R1: While reset is asserted and after it is released, every `nmos_on` bit is 0 (transistor off, pin high), the select mask is 0, the port register is all ones, and every shadow and active duty is 0.
- R2: `ld_ready` is always 1. On a clock edge where `ld_valid` is 1, `ld_data` is written to the shadow register of channel `ld_chan` (0 to 3), and no other channel is affected.
- R3: The tick counter advances once every DIV clocks and wraps from 255 to 0, so one period is 256*DIV clocks long.
- R4: For a channel in pulse-width mode with active duty N, `nmos_on` is 0 while the tick count is below N and 1 for the rest of the period.
- R5: A channel in pulse-width mode with active duty 0 keeps `nmos_on` at 1 for the whole period.
- R6: A shadow value becomes active only on the clock edge where the count wraps from 255 to 0, and all four channels take their shadow values on that same edge. Until then the previous duty keeps driving the output.
- R7: A pin whose select bit is 0 drives `nmos_on` as the inverse of its port bit: port bit 1 gives a high pin (`nmos_on`=0). Selection is independent for each bit.
- R8: A configuration write (`cfg_we`=1) loads the select mask and the port register on that edge, and the pins show the new selection from the next clock on without waiting for a period boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ld_valid | input | 1 | Load command present |
| ld_ready | output | 1 | Load accepted; always 1 |
| ld_chan | input | 2 | Target channel of the load command |
| ld_data | input | 8 | Duty value for the target channel |
| cfg_we | input | 1 | Write strobe for select mask and port register |
| cfg_dac_sel | input | 4 | Per-pin select: 1 = pulse-width output, 0 = port bit |
| cfg_port | input | 4 | Port register value: 1 = pin high (transistor off) |
| nmos_on | output | 4 | Pull-down transistor drive per pin; 1 = pin pulled low |

## Verification
A load lands in the shadow register on its accepting edge but reaches a pin only after the next wrap edge. A configuration write changes the pins one clock after the edge that accepts it. The pin outputs are combinational from registers, so any change shows up in the same clock as the register that causes it. The bench's reference model updates on the same rising edges as the design and compares the whole output vector on every falling edge. Because inputs change only on falling edges, each result is sampled half a clock after the edge that should produce it.

// File: rtl/qpd_pkg.sv
package qpd_pkg;
  localparam int DEF_NUM_CH = 4;
  localparam int DEF_DUTY_W = 8;
  localparam int DEF_DIV    = 2;
endpackage

// File: rtl/qpd_timebase.sv
module qpd_timebase #(
  parameter int DIV = 2,
  parameter int CW  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic          wrap,
  output logic [CW-1:0] cnt
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] PRE_LAST = PW'(DIV - 1);

  logic [PW-1:0] pre;
  logic          tick;

  assign tick = (pre == PRE_LAST);
  assign wrap = tick && (cnt == {CW{1'b1}});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre <= '0;
      cnt <= '0;
    end else begin
      if (tick) begin
        pre <= '0;
        cnt <= cnt + CW'(1);
      end else begin
        pre <= pre + PW'(1);
      end
    end
  end
endmodule

// File: rtl/qpd_channel.sv
module qpd_channel #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld,
  input  logic [DW-1:0] ld_data,
  input  logic          wrap,
  output logic [DW-1:0] active_q
);
  logic [DW-1:0] shadow_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= '0;
      active_q <= '0;
    end else begin
      if (wrap) active_q <= shadow_q;
      if (ld)   shadow_q <= ld_data;
    end
  end
endmodule

// File: rtl/qpd_pinmux.sv
module qpd_pinmux #(
  parameter int NUM_CH = 4,
  parameter int DW     = 8
) (
  input  logic [DW-1:0]        cnt,
  input  logic [NUM_CH*DW-1:0] act_flat,
  input  logic [NUM_CH-1:0]    sel,
  input  logic [NUM_CH-1:0]    port,
  output logic [NUM_CH-1:0]    nmos_on
);
  for (genvar i = 0; i < NUM_CH; i++) begin : g_pin
    logic pwm_high;
    assign pwm_high   = (cnt < act_flat[i*DW +: DW]);
    assign nmos_on[i] = sel[i] ? ~pwm_high : ~port[i];
  end
endmodule

// File: rtl/quad_pwm_dac.sv
module quad_pwm_dac #(
  parameter int NUM_CH = qpd_pkg::DEF_NUM_CH,
  parameter int DUTY_W = qpd_pkg::DEF_DUTY_W,
  parameter int DIV    = qpd_pkg::DEF_DIV
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      ld_valid,
  output logic                      ld_ready,
  input  logic [$clog2(NUM_CH)-1:0] ld_chan,
  input  logic [DUTY_W-1:0]         ld_data,
  input  logic                      cfg_we,
  input  logic [NUM_CH-1:0]         cfg_dac_sel,
  input  logic [NUM_CH-1:0]         cfg_port,
  output logic [NUM_CH-1:0]         nmos_on
);
  localparam int CHW = $clog2(NUM_CH);

  logic                     wrap;
  logic [DUTY_W-1:0]        cnt;
  logic [NUM_CH*DUTY_W-1:0] act_flat;
  logic [NUM_CH-1:0]        sel_q;
  logic [NUM_CH-1:0]        port_q;

  assign ld_ready = 1'b1;

  qpd_timebase #(.DIV(DIV), .CW(DUTY_W)) u_tb (
    .clk(clk), .rst_n(rst_n), .wrap(wrap), .cnt(cnt)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    qpd_channel #(.DW(DUTY_W)) u_ch (
      .clk(clk),
      .rst_n(rst_n),
      .ld(ld_valid && (ld_chan == CHW'(i))),
      .ld_data(ld_data),
      .wrap(wrap),
      .active_q(act_flat[i*DUTY_W +: DUTY_W])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= '0;
      port_q <= '1;
    end else if (cfg_we) begin
      sel_q  <= cfg_dac_sel;
      port_q <= cfg_port;
    end
  end

  qpd_pinmux #(.NUM_CH(NUM_CH), .DW(DUTY_W)) u_mux (
    .cnt(cnt), .act_flat(act_flat), .sel(sel_q), .port(port_q), .nmos_on(nmos_on)
  );
endmodule

// File: rtl/qpd_checker.sv
module qpd_checker #(
  parameter int NUM_CH = 4,
  parameter int DW     = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 wrap,
  input logic [DW-1:0]        cnt,
  input logic [NUM_CH*DW-1:0] act_flat,
  input logic [NUM_CH-1:0]    sel_q,
  input logic [NUM_CH-1:0]    port_q,
  input logic [NUM_CH-1:0]    nmos_on
);
  assert_cnt_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cnt) |-> (cnt == $past(cnt) + DW'(1)));

  assert_act_at_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(act_flat) |-> $past(wrap));

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
    assert_zero_duty_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_q[i] && (act_flat[i*DW +: DW] == '0)) |-> nmos_on[i]);

    assert_port_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!sel_q[i] && $stable(sel_q[i]) && $stable(port_q[i])) |-> $stable(nmos_on[i]));
  end
endmodule

bind quad_pwm_dac qpd_checker #(.NUM_CH(NUM_CH), .DW(DUTY_W)) u_qpd_chk (
  .clk(clk), .rst_n(rst_n), .wrap(wrap), .cnt(cnt), .act_flat(act_flat),
  .sel_q(sel_q), .port_q(port_q), .nmos_on(nmos_on)
);

// File: tb/quad_pwm_dac_test.sv
`timescale 1ns/1ps
module quad_pwm_dac_test;
  localparam int DIV = 2;
  localparam int PER = 256 * DIV;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ld_valid = 1'b0;
  logic [1:0] ld_chan = '0;
  logic [7:0] ld_data = '0;
  logic       cfg_we = 1'b0;
  logic [3:0] cfg_dac_sel = '0;
  logic [3:0] cfg_port = '0;
  logic       ld_ready;
  logic [3:0] nmos_on;

  always #2 clk = ~clk;

  quad_pwm_dac #(.NUM_CH(4), .DUTY_W(8), .DIV(DIV)) uut (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_ready(ld_ready),
    .ld_chan(ld_chan), .ld_data(ld_data), .cfg_we(cfg_we),
    .cfg_dac_sel(cfg_dac_sel), .cfg_port(cfg_port), .nmos_on(nmos_on)
  );

  int    checks = 0;
  int    fails = 0;
  bit    cmp_en = 1'b0;
  bit    done = 1'b0;
  string tag = "R1";

  // behavioural reference model
  int       m_pre, m_cnt;
  int       m_sh[4];
  int       m_ac[4];
  bit [3:0] m_sel, m_port;

  always @(posedge clk) begin
    bit wr;
    if (!rst_n) begin
      m_pre = 0; m_cnt = 0; m_sel = '0; m_port = '1;
      for (int i = 0; i < 4; i++) begin m_sh[i] = 0; m_ac[i] = 0; end
    end else begin
      wr = (m_pre == DIV - 1) && (m_cnt == 255);
      if (m_pre == DIV - 1) begin m_pre = 0; m_cnt = (m_cnt + 1) % 256; end
      else m_pre = m_pre + 1;
      if (wr) for (int i = 0; i < 4; i++) m_ac[i] = m_sh[i];
      if (ld_valid) m_sh[ld_chan] = ld_data;
      if (cfg_we) begin m_sel = cfg_dac_sel; m_port = cfg_port; end
    end
  end

  function automatic bit [3:0] model_out();
    bit [3:0] e;
    for (int i = 0; i < 4; i++)
      e[i] = m_sel[i] ? !(m_cnt < m_ac[i]) : !m_port[i];
    return e;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_en && rst_n && !done) begin
      bit [3:0] e;
      string t;
      e = model_out();
      t = tag;
      for (int i = 0; i < 4; i++)
        if (m_sel[i] && m_ac[i] == 0 && e[i] !== nmos_on[i]) t = "R5";
      check(t, 32'(nmos_on), 32'(e));
    end
  end

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load(int ch, int d);
    @(negedge clk);
    ld_valid = 1'b1; ld_chan = 2'(ch); ld_data = 8'(d);
    @(negedge clk);
    ld_valid = 1'b0;
  endtask

  task automatic config_pins(logic [3:0] s, logic [3:0] p);
    @(negedge clk);
    cfg_we = 1'b1; cfg_dac_sel = s; cfg_port = p;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  initial begin
    int gap;
    int guard;
    wait_clk(3);
    check("R1", 32'(nmos_on), 32'h0);
    rst_n = 1'b1;
    cmp_en = 1'b1;
    wait_clk(1);
    check("R1", 32'(nmos_on), 32'h0);
    check("R2", 32'(ld_ready), 32'h1);

    tag = "R7";
    config_pins(4'b0000, 4'b0101);
    check("R7", 32'(nmos_on), 32'hA);
    wait_clk(10);

    tag = "R2";
    load(0, 0); load(1, 1); load(2, 128); load(3, 255);
    check("R2", 32'(ld_ready), 32'h1);

    tag = "R8";
    config_pins(4'b1111, 4'b1111);
    // actives still zero before the first wrap: all pulled low at once
    check("R8", 32'(nmos_on), 32'hF);
    tag = "R6";
    wait_clk(20);
    check("R6", 32'(nmos_on), 32'hF);

    tag = "R4";
    wait_clk(2 * PER);
    check("R5", 32'(nmos_on[0]), 32'h1);

    tag = "R6";
    wait_clk(PER / 3);
    load(2, 10);
    load(0, 200);
    wait_clk(PER + PER / 2);

    tag = "R7";
    config_pins(4'b1010, 4'b0011);
    wait_clk(PER);
    check("R7", 32'(nmos_on[0]), 32'h0);
    check("R7", 32'(nmos_on[2]), 32'h1);

    tag = "R3";
    load(0, 1);
    config_pins(4'b0001, 4'b0000);
    wait_clk(PER + 4);
    guard = 0;
    while (!(nmos_on[0] == 1'b0) && guard < 2 * PER) begin wait_clk(1); guard++; end
    while (nmos_on[0] == 1'b0 && guard < 4 * PER) begin wait_clk(1); guard++; end
    gap = 0;
    while (nmos_on[0] == 1'b1 && gap < 2 * PER) begin wait_clk(1); gap++; end
    while (nmos_on[0] == 1'b0 && gap < 2 * PER) begin wait_clk(1); gap++; end
    check("R3", 32'(gap), 32'(PER));

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule